// File: doc/BRIEF.md
# Cascadable Triple Interval Timer

This block contains three 16-bit binary down-counters, known as counters 3, 4 and 5. Each one runs as a periodic rate generator. Software writes a reload value, and the counter then produces one low-going output pulse every N timer ticks. A free-running divide-by-8 prescaler on the system clock makes the internal tick. Counters 3 and 4 can each count rising edges of their own external clock pin instead. Each external pin is first brought into the system clock domain by a synchroniser and then reduced to a one-cycle pulse by an edge detector.

A single 8-bit control register sets three things:

- the gate level of each counter;
- the clock source of counters 3 and 4;
- whether counters 4 and 5 form one 32-bit timer.

In the 32-bit arrangement, each terminal-count pulse of counter 4 advances counter 5 by one. Counter 4 holds the low half and counter 5 the high half. A host reaches all registers over a simple byte-wide bus with a write strobe and a registered read path. Each counter also has a mode byte. This byte is stored and read back but does not affect counting, since only binary counting exists.

Top module: `casc_interval_timer`

## Requirements
- R1: After reset, the control register reads 0x00, every counter value reads 0 and all three timer outputs are high.
- R2: Control register (address 0x0) bit map: bit 7, 6 and 5 are the gates of counters 5, 4 and 3; bit 4 is the pairing select; bit 3 and bit 2 are the clock selects of counters 4 and 3. Bits 7 to 2 read back as written, and bits 1 and 0 ignore writes and always read 0.
- R3: A gate bit of 0 holds its counter's value unchanged, and a gate bit of 1 lets that counter decrement on its ticks.
- R4: With a clock select of 0, a counter ticks once every 8 system clock cycles, so a reload of N gives an output period of 8·N cycles with one 8-cycle low phase.
- R5: In rate-generator operation, the count steps down from N to 1, the output is low for the tick spent at 1, and the counter then reloads N. A reload of 0 acts as 65536, so the first tick after loading 0 gives 0xFFFF.
- R6: The reload port of counter k (addresses 0x4, 0x5, 0x6 for counters 3, 4, 5) takes the low byte first and then the high byte. A low-byte write alone leaves the count unchanged. The high-byte write copies the 16-bit value into the count at once, and counting starts on the next tick. Counts read at 0x8/0x9, 0xA/0xB and 0xC/0xD as low/high bytes.
- R7: A clock select of 1 makes counter 3 (bit 2) or counter 4 (bit 3) decrement exactly once per rising edge of its external clock pin (ext_clk_in[0] or ext_clk_in[1]).
- R8: With bit 4 at 0, counter 5 decrements only on counter 4's terminal-count events, so its period is the product of the two reloads in internal ticks. With bit 4 at 1, counter 5 runs on the internal tick.
- R9: The mode byte of each counter (addresses 0x1, 0x2, 0x3) reads back as written. Setting its bit 0 (decimal-count request) leaves counting binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe, one cycle per byte |
| bus_addr | input | ADDR_W | Host register address (write and read) |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |
| ext_clk_in | input | 2 | External clock pins: [0] for counter 3, [1] for counter 4 |
| tmr_out | output | 3 | Timer outputs, [0] counter 3 to [2] counter 5, low for one counter tick per period |

## Verification
The bench measures output periods and low-phase widths in system cycles. This exposes a prescaler that divides by the wrong amount, an off-by-one reload that gives N±1 ticks, and a cascade that feeds counter 5 the internal tick, which would give 24 cycles instead of 96. It writes only the low byte of a reload and confirms that the count does not move. A design that loads on the first byte would show the new value. It loads 0 and expects 0xFFxx afterwards, which fails if 0 is taken as a stop or a one-tick period. It also sends a counted burst of slow external edges and expects the exact decrement. A missing synchroniser stage would still pass, but a detector that fires on a level or on both edges would over-count.

// File: rtl/tmr3_pkg.sv
package tmr3_pkg;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 2 * BYTE_W;
  localparam int NUM_CNT = 3;

  // host address map (byte registers)
  localparam int A_CTRL    = 0;
  localparam int A_MODE0   = 1;   // mode byte of counter k at A_MODE0 + k
  localparam int A_RELOAD0 = 4;   // reload port of counter k at A_RELOAD0 + k
  localparam int A_COUNT0  = 8;   // count of counter k: low at A_COUNT0 + 2k, high one above

  // stored bits of the control register, bits 7..2; bits 1..0 are not kept
  typedef struct packed {
    logic [NUM_CNT-1:0] gate;     // [2] counter 5, [1] counter 4, [0] counter 3
    logic               pair_off; // 0: counters 4 and 5 chained
    logic [1:0]         ext_sel;  // [1] counter 4, [0] counter 3
  } ctrl_t;
endpackage

// File: rtl/tmr3_prescale.sv
module tmr3_prescale #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;
  logic          tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      tick_q <= (cnt_q == LAST);
    end
  end

  assign tick = tick_q;

  generate
    if (DIV > 1) begin : g_spacing
      // R4
      tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q);
    end
  endgenerate
endmodule

// File: rtl/tmr3_edge_sync.sv
module tmr3_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;
  logic            rise_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      rise_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-1:0], din};
      rise_q <= sh_q[STAGES-1] & ~sh_q[STAGES];
    end
  end

  assign rise = rise_q;

  // R7
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rise_q |=> !rise_q);
endmodule

// File: rtl/tmr3_counter.sv
module tmr3_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         gate,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         tc,
  output logic         out_n
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] count_q;
  logic [W-1:0] reload_q;
  logic         armed_q;
  logic         out_q;
  logic         step;

  assign step = tick & gate & armed_q;
  assign tc   = step & (count_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      reload_q <= '0;
      armed_q  <= 1'b0;
      out_q    <= 1'b1;
    end else begin
      if (load) begin
        count_q  <= load_val;
        reload_q <= load_val;
        armed_q  <= 1'b1;
      end else if (step) begin
        count_q  <= (count_q == ONE) ? reload_q : count_q - 1'b1;
      end
      out_q <= ~(armed_q && (count_q == ONE));
    end
  end

  assign count = count_q;
  assign out_n = out_q;

  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!gate && !load) |=> $stable(count_q));
  // R5
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (tc && !load) |=> (count_q == $past(reload_q)));
  // R6
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (count_q == $past(load_val)));
endmodule

// File: rtl/casc_interval_timer.sv
module casc_interval_timer
  import tmr3_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int PRESC_DIV = 8,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [1:0]        ext_clk_in,
  output logic [2:0]        tmr_out
);
  ctrl_t              ctrl_q;
  logic [BYTE_W-1:0]  mode_q    [NUM_CNT];
  logic [BYTE_W-1:0]  lo_hold_q [NUM_CNT];
  logic [NUM_CNT-1:0] hi_ptr_q;
  logic [NUM_CNT-1:0] load;
  logic [CNT_W-1:0]   load_val  [NUM_CNT];
  logic [CNT_W-1:0]   count_w   [NUM_CNT];
  logic [NUM_CNT-1:0] tc;
  logic [NUM_CNT-1:0] tick_sel;
  logic [NUM_CNT-1:0] out_w;
  logic [1:0]         ext_rise;
  logic               int_tick;
  logic [7:0]         rd_mux;
  logic [7:0]         rdata_q;

  // ---------------- host writes ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      hi_ptr_q <= '0;
      for (int k = 0; k < NUM_CNT; k++) begin
        mode_q[k]    <= '0;
        lo_hold_q[k] <= '0;
      end
    end else if (bus_wr) begin
      if (bus_addr == ADDR_W'(A_CTRL))
        ctrl_q <= bus_wdata[7:2];
      for (int k = 0; k < NUM_CNT; k++) begin
        if (bus_addr == ADDR_W'(A_MODE0 + k)) begin
          mode_q[k]   <= bus_wdata;
          hi_ptr_q[k] <= 1'b0;
        end
        if (bus_addr == ADDR_W'(A_RELOAD0 + k)) begin
          if (!hi_ptr_q[k]) lo_hold_q[k] <= bus_wdata;
          hi_ptr_q[k] <= ~hi_ptr_q[k];
        end
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_CNT; k++) begin
      load[k]     = bus_wr && (bus_addr == ADDR_W'(A_RELOAD0 + k)) && hi_ptr_q[k];
      load_val[k] = {bus_wdata, lo_hold_q[k]};
    end
  end

  // ---------------- host reads ----------------
  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(A_CTRL))
      rd_mux = {ctrl_q, 2'b00};
    for (int k = 0; k < NUM_CNT; k++) begin
      if (bus_addr == ADDR_W'(A_MODE0 + k))
        rd_mux = mode_q[k];
      if (bus_addr == ADDR_W'(A_COUNT0 + 2 * k))
        rd_mux = count_w[k][BYTE_W-1:0];
      if (bus_addr == ADDR_W'(A_COUNT0 + 2 * k + 1))
        rd_mux = count_w[k][CNT_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end
  assign bus_rdata = rdata_q;

  // ---------------- tick sources ----------------
  tmr3_prescale #(.DIV(PRESC_DIV)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .tick (int_tick)
  );

  generate
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
      if (k < 2) begin : g_ext
        tmr3_edge_sync #(.STAGES(SYNC_STG)) u_sync (
          .clk  (clk),
          .rst  (rst),
          .din  (ext_clk_in[k]),
          .rise (ext_rise[k])
        );
        assign tick_sel[k] = ctrl_q.ext_sel[k] ? ext_rise[k] : int_tick;
      end else begin : g_chain
        assign tick_sel[k] = ctrl_q.pair_off ? int_tick : tc[1];
      end

      tmr3_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .gate     (ctrl_q.gate[k]),
        .tick     (tick_sel[k]),
        .load     (load[k]),
        .load_val (load_val[k]),
        .count    (count_w[k]),
        .tc       (tc[k]),
        .out_n    (out_w[k])
      );
    end
  endgenerate

  assign tmr_out = out_w;

  // R2
  ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADDR_W'(A_CTRL)) |-> (bus_rdata[1:0] == 2'b00));
  // R8
  chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.pair_off && !tc[1] && !load[2]) |=> $stable(count_w[2]));
endmodule

// File: tb/casc_interval_timer_tb_top.sv
module casc_interval_timer_tb_top;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0]        bus_wdata = '0;
  logic [7:0]        bus_rdata;
  logic [1:0]        ext_clk_in = 2'b00;
  logic [2:0]        tmr_out;

  always #2.5 clk = ~clk;   // 200 MHz

  casc_interval_timer #(.ADDR_W(ADDR_W)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ext_clk_in (ext_clk_in),
    .tmr_out    (tmr_out)
  );

  typedef struct {
    int    lo;
    int    hi;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  logic stb = 1'b0;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // monitor: pops one expectation per strobe and compares the read data
  always @(posedge clk) begin
    if (stb && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (int'(bus_rdata) < e.lo || int'(bus_rdata) > e.hi) begin
        n_bad++;
        $display("FAIL %s: read 0x%02h expected 0x%02h..0x%02h", e.tag, bus_rdata, e.lo, e.hi);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reload(input int k, input int v);
    wr(4 + k, v & 8'hFF);
    wr(4 + k, (v >> 8) & 8'hFF);
  endtask

  task automatic rd_chk(input int a, input int lo, input int hi, input string tag);
    exp_t e;
    @(negedge clk);
    bus_addr = ADDR_W'(a);
    @(negedge clk);
    e.lo = lo; e.hi = hi; e.tag = tag;
    exp_q.push_back(e);
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // wait for a falling edge of tmr_out[idx], then measure low width and period
  task automatic meas(input int idx, input int exp_per, input int exp_low, input string tag);
    int   guard = 0;
    int   low_c = 0;
    int   per_c = 0;
    logic prev;
    @(negedge clk);
    prev = tmr_out[idx];
    while (!(prev == 1'b1 && tmr_out[idx] == 1'b0) && guard < 5000) begin
      prev = tmr_out[idx];
      @(negedge clk);
      guard++;
    end
    if (guard >= 5000) begin
      chk({tag, " no output pulse"}, 0, 1);
    end else begin
      while (tmr_out[idx] == 1'b0 && low_c < 5000) begin
        @(negedge clk); low_c++;
      end
      per_c = low_c;
      while (tmr_out[idx] == 1'b1 && per_c < 5000) begin
        @(negedge clk); per_c++;
      end
      chk({tag, " low width"}, low_c, exp_low);
      chk({tag, " period"}, per_c, exp_per);
    end
  endtask

  task automatic ext_edges(input int k, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_clk_in[k] = 1'b1;
      repeat (3) @(negedge clk);
      ext_clk_in[k] = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd_chk(0, 8'h00, 8'h00, "R1 ctrl");
    rd_chk(8, 0, 0, "R1 count3 lo");
    rd_chk(9, 0, 0, "R1 count3 hi");
    rd_chk(12, 0, 0, "R1 count5 lo");
    chk("R1 outputs", int'(tmr_out), 7);

    // R2 reserved bits
    wr(0, 8'hFF);
    rd_chk(0, 8'hFC, 8'hFC, "R2 ctrl readback");
    wr(0, 8'h00);

    // R6 byte order, gate off
    reload(0, 1000);
    rd_chk(8, 8'hE8, 8'hE8, "R6 lo after load");
    rd_chk(9, 8'h03, 8'h03, "R6 hi after load");
    wr(4, 8'h05);
    rd_chk(8, 8'hE8, 8'hE8, "R6 low byte alone");
    wr(4, 8'h00);
    rd_chk(8, 8'h05, 8'h05, "R6 lo after high byte");
    rd_chk(9, 8'h00, 8'h00, "R6 hi after high byte");

    // R3 gate hold and release
    reload(0, 1000);
    repeat (50) @(negedge clk);
    rd_chk(8, 8'hE8, 8'hE8, "R3 halted");
    wr(0, 8'h20);
    repeat (100) @(negedge clk);
    rd_chk(9, 8'h03, 8'h03, "R3 running hi");
    rd_chk(8, 8'hD4, 8'hE3, "R3 running lo");

    // R4 internal tick period
    reload(0, 5);
    meas(0, 40, 8, "R4 N=5");

    // R5 other N and zero load
    reload(0, 3);
    meas(0, 24, 8, "R5 N=3");
    reload(0, 0);
    repeat (40) @(negedge clk);
    rd_chk(9, 8'hFF, 8'hFF, "R5 zero load hi");
    rd_chk(8, 8'hF0, 8'hFF, "R5 zero load lo");

    // R9 mode byte stored, counting stays binary
    wr(1, 8'h01);
    rd_chk(1, 8'h01, 8'h01, "R9 mode readback");
    wr(3, 8'hA5);
    rd_chk(3, 8'hA5, 8'hA5, "R9 mode5 readback");
    reload(0, 26);
    meas(0, 208, 8, "R9 binary N=26");

    // R7 external clocks
    wr(0, 8'h24);
    reload(0, 100);
    ext_edges(0, 10);
    rd_chk(8, 90, 90, "R7 ext counter3");
    wr(0, 8'h58);
    reload(1, 50);
    ext_edges(1, 7);
    rd_chk(10, 43, 43, "R7 ext counter4");
    rd_chk(8, 90, 90, "R7 counter3 gated off");

    // R8 chained and unchained counter 5
    wr(0, 8'h80);
    reload(2, 7);
    repeat (100) @(negedge clk);
    rd_chk(12, 7, 7, "R8 chained, counter4 gated off");
    wr(0, 8'hC0);
    reload(1, 4);
    reload(2, 3);
    meas(2, 96, 32, "R8 chained");
    wr(0, 8'hD0);
    meas(2, 24, 8, "R8 unchained");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule